// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps one processor's private write-back cache coherent with the other caches on a shared bus. It holds a small direct-mapped array of one-word lines. Each line carries a tag, a data word and a coherence state of Invalid, Shared or Modified. Processor loads and stores that the current state allows finish at once. Anything else becomes a bus transaction: a shared fetch, an exclusive fetch, or a writeback of a dirty victim. Each transaction waits for a request/grant handshake, and the data arrives in the cycle of the grant.

The controller also watches every transaction that other caches place on the bus. If another cache fetches a line that this cache holds Modified, the controller drives the word onto its supply port in the same cycle and demotes the line. If another cache asks for exclusive ownership, the local copy is dropped. The pending processor request is derived from the array contents on every cycle. A snoop that changes the target line therefore changes the request that follows it.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so `cpu_ready`, `bus_req` and `snp_flush` are low while idle, and the first read at any index raises `bus_req` with command 1 (shared fetch).
- R2: A read that misses (line Invalid or tag differs, no dirty victim) raises `bus_req` with command 1 and the word address. On grant the line takes `bus_rdata` and becomes Shared. The read completes one cycle later with that data.
- R3: A write to a line that is Invalid, holds another tag, or is Shared raises `bus_req` with command 2 (exclusive fetch). On grant the line becomes Modified, and the write completes the next cycle.
- R4: Reads of Shared or Modified lines, and writes of Modified lines, assert `cpu_ready` in the cycle of the request with no `bus_req`. A read returns the stored word on `cpu_rdata`.
- R5: A snooped command 1 hitting a Modified line asserts `snp_flush` in that cycle with the line's word on `snp_data`, and leaves the line Shared.
- R6: A snooped command 2 hitting a Modified line asserts `snp_flush` with the word and leaves the line Invalid.
- R7: A snooped command 2 hitting a Shared line makes it Invalid without asserting `snp_flush`.
- R8: A snooped command 1 hitting a Shared line has no effect. A snooped command 3 (writeback) or a snoop whose tag misses has no effect. None of these asserts `snp_flush`.
- R9: A miss whose line is Modified with a different tag first raises `bus_req` with command 3, the victim's address and `bus_wdata` equal to its word. On grant the victim becomes Invalid, and only after that is the fetch requested.
- R10: `cpu_ready` stays low until every bus transaction a request needs has been granted. In a cycle with `snp_valid` high, neither `cpu_ready` nor `bus_req` is asserted.
- R11: A snoop that invalidates the line a pending request is waiting on changes the next request. A pending victim writeback whose victim is snooped away becomes the fetch directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 shared fetch, 2 exclusive fetch, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback word |
| bus_gnt | input | 1 | Grant; transaction completes this cycle |
| bus_rdata | input | DATA_W | Fetched word, valid with grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Supplied word |

## Verification
A wrong line state shows up at the ports within one access. A line left Shared where it should be Modified makes the next write ask for an exclusive fetch. A line left Modified where it should be Invalid or Shared makes the next snoop assert `snp_flush`. A stale Invalid turns a hit into a bus request in the same cycle. A lost dirty word is caught at the next eviction or supply, where `bus_wdata` or `snp_data` is compared with a word model kept by the bench. Most of the random stimulus uses three tags per index, so conflicts and evictions are frequent.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} msi_t;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3
  } bcmd_t;

  function automatic logic cpu_hits(msi_t s, logic we);
    return we ? (s == ST_M) : (s != ST_I);
  endfunction

  function automatic bcmd_t fill_cmd(logic we);
    return we ? CMD_RDX : CMD_RD;
  endfunction

  function automatic msi_t fill_state(logic we);
    return we ? ST_M : ST_S;
  endfunction

  function automatic msi_t snoop_next(msi_t s, bcmd_t c);
    if (c == CMD_RDX) return ST_I;
    if (c == CMD_RD && s == ST_M) return ST_S;
    return s;
  endfunction

  function automatic logic snoop_supplies(msi_t s, bcmd_t c);
    return (s == ST_M) && (c == CMD_RD || c == CMD_RDX);
  endfunction
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output msi_t              a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output msi_t              b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  msi_t              w_st,
  input  logic              w_tag_en,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              w_data_en,
  input  logic [DATA_W-1:0] w_data
);
  msi_t              st_v   [LINES];
  logic [TAG_W-1:0]  tag_v  [LINES];
  logic [DATA_W-1:0] data_v [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    msi_t              st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    wire sel = w_en && (w_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= ST_I;
        tag_q  <= '0;
        data_q <= '0;
      end else if (sel) begin
        st_q <= w_st;
        if (w_tag_en)  tag_q  <= w_tag;
        if (w_data_en) data_q <= w_data;
      end
    end
    assign st_v[i]   = st_q;
    assign tag_v[i]  = tag_q;
    assign data_v[i] = data_q;
  end

  assign a_st   = st_v[a_idx];
  assign a_tag  = tag_v[a_idx];
  assign a_data = data_v[a_idx];
  assign b_st   = st_v[b_idx];
  assign b_tag  = tag_v[b_idx];
  assign b_data = data_v[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              snp_valid,
  input  bcmd_t             snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  msi_t              line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd,
  output msi_t              nxt_st,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data
);
  logic hit;
  assign hit        = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign nxt_st     = snoop_next(line_st, snp_cmd);
  assign upd        = hit && (nxt_st != line_st);
  assign flush      = hit && snoop_supplies(line_st, snp_cmd);
  assign flush_data = line_data;
endmodule

// File: rtl/msi_miss_unit.sv
module msi_miss_unit
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic              snp_valid,
  input  msi_t              line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit,
  output logic              victim_wb,
  output logic              need_bus,
  output bcmd_t             cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  logic same_tag;
  assign same_tag  = (line_st != ST_I) && (line_tag == cpu_tag);
  assign hit       = same_tag && cpu_hits(line_st, cpu_we);
  assign victim_wb = (line_st == ST_M) && (line_tag != cpu_tag);
  assign need_bus  = cpu_req && !hit && !snp_valid;
  assign cmd       = victim_wb ? CMD_WB : fill_cmd(cpu_we);
  assign addr      = victim_wb ? {line_tag, cpu_idx} : {cpu_tag, cpu_idx};
  assign wdata     = line_data;
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  wire [IDX_W-1:0] cpu_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] snp_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] snp_tag = snp_addr[ADDR_W-1:IDX_W];

  msi_t              cpu_st, snp_st, snp_nxt, w_st;
  logic [TAG_W-1:0]  cpu_ltag, snp_ltag, w_tag;
  logic [DATA_W-1:0] cpu_ldata, snp_ldata, w_data;
  logic              w_en, w_tag_en, w_data_en;
  logic [IDX_W-1:0]  w_idx;
  logic              cpu_hit, victim_wb, snp_upd;
  bcmd_t             req_cmd;

  msi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_st(cpu_st), .a_tag(cpu_ltag), .a_data(cpu_ldata),
    .b_idx(snp_idx), .b_st(snp_st), .b_tag(snp_ltag), .b_data(snp_ldata),
    .w_en(w_en), .w_idx(w_idx), .w_st(w_st), .w_tag_en(w_tag_en),
    .w_tag(w_tag), .w_data_en(w_data_en), .w_data(w_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
    .snp_valid(snp_valid), .snp_cmd(bcmd_t'(snp_cmd)), .snp_tag(snp_tag),
    .line_st(snp_st), .line_tag(snp_ltag), .line_data(snp_ldata),
    .upd(snp_upd), .nxt_st(snp_nxt), .flush(snp_flush), .flush_data(snp_data)
  );

  msi_miss_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_miss (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
    .snp_valid(snp_valid), .line_st(cpu_st), .line_tag(cpu_ltag),
    .line_data(cpu_ldata), .hit(cpu_hit), .victim_wb(victim_wb),
    .need_bus(bus_req), .cmd(req_cmd), .addr(bus_addr), .wdata(bus_wdata)
  );

  // Named events for the checker
  wire bus_done  = bus_req && bus_gnt;
  wire cpu_store = cpu_ready && cpu_we;

  assign bus_cmd   = req_cmd;
  assign cpu_ready = cpu_req && cpu_hit && !snp_valid;
  assign cpu_rdata = cpu_ldata;

  // Single write port: snoop update, bus completion and store are exclusive
  always_comb begin
    w_en      = 1'b0;
    w_idx     = cpu_idx;
    w_st      = cpu_st;
    w_tag_en  = 1'b0;
    w_tag     = cpu_tag;
    w_data_en = 1'b0;
    w_data    = cpu_wdata;
    if (snp_upd) begin
      w_en  = 1'b1;
      w_idx = snp_idx;
      w_st  = snp_nxt;
    end else if (bus_done) begin
      w_en = 1'b1;
      if (victim_wb) begin
        w_st = ST_I;
      end else begin
        w_st      = fill_state(cpu_we);
        w_tag_en  = 1'b1;
        w_data_en = 1'b1;
        w_data    = bus_rdata;
      end
    end else if (cpu_store) begin
      w_en      = 1'b1;
      w_data_en = 1'b1;
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
  import msi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_done,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_flush,
  input msi_t       cpu_st
);
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req); // R4
  AST_FLUSH_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX)); // R5
  AST_SNOOP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_req && !cpu_ready); // R10
  AST_RD_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && bus_cmd == CMD_RD && cpu_req) |=> cpu_st == ST_S); // R2
  AST_RDX_FILL_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && bus_cmd == CMD_RDX && cpu_req) |=> cpu_st == ST_M); // R3
  AST_WB_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && bus_cmd == CMD_WB && cpu_req) |=> cpu_st == ST_I); // R9
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_done(bus_done), .bus_cmd(bus_cmd),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_flush(snp_flush),
  .cpu_st(cpu_st)
);

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       cpu_req = 0, cpu_we = 0, cpu_ready;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic       bus_req, bus_gnt = 0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic       snp_valid = 0, snp_flush;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0, snp_data;

  int checks = 0, fails = 0;
  int m_st[8];  // 0 invalid, 1 shared, 2 modified
  int m_tag[8];
  logic [7:0] m_data[8];
  logic [7:0] mem[256];

  always #2.5 clk = ~clk;

  msi_snoop_ctrl i_msi_snoop_ctrl (.*);

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_init(int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic bit model_hit(bit we, int idx, int tg);
    if (m_st[idx] == 0 || m_tag[idx] != tg) return 0;
    return we ? (m_st[idx] == 2) : 1;
  endfunction

  task automatic cpu_op(bit we, logic [7:0] addr, logic [7:0] wd);
    int idx = int'(addr[2:0]);
    int tg = int'(addr[7:3]);
    int ec[2]; int ea[2]; int n = 0; int k = 0; bit done = 0;
    string rq;
    bit hit = model_hit(we, idx, tg);
    rq = hit ? "R4" : (we ? "R3" : "R2");
    if (!hit) begin
      if (m_st[idx] == 2 && m_tag[idx] != tg) begin
        ec[n] = 3; ea[n] = m_tag[idx] * 8 + idx; n++;
      end
      ec[n] = we ? 2 : 1; ea[n] = int'(addr); n++;
    end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    for (int c = 0; c < 60 && !done; c++) begin
      #1;
      if (cpu_ready) begin
        chk(k == n && !bus_req, "R10", k, n);
        if (!we) chk(cpu_rdata == m_data[idx], rq, cpu_rdata, m_data[idx]);
        else begin m_data[idx] = wd; m_st[idx] = 2; end
        done = 1;
      end else if (bus_req) begin
        string tq = (k < n && ec[k] == 3) ? "R9" : rq;
        chk(k < n && int'(bus_cmd) == ec[k] && int'(bus_addr) == ea[k], tq,
            {bus_cmd, bus_addr}, k < n ? ec[k] * 256 + ea[k] : 0);
        if (k < n && ec[k] == 3)
          chk(bus_wdata == m_data[idx], "R9", bus_wdata, m_data[idx]);
        if ($urandom % 3 != 0) begin
          bus_gnt = 1; bus_rdata = mem[bus_addr];
          if (k < n && ec[k] == 3) begin
            mem[ea[k]] = m_data[idx]; m_st[idx] = 0;
          end else begin
            m_tag[idx] = tg; m_data[idx] = mem[addr]; m_st[idx] = we ? 2 : 1;
          end
          k++;
        end
      end else begin
        chk(0, "R10", 0, 1);
        done = 1;
      end
      @(negedge clk);
      bus_gnt = 0;
    end
    if (!done) chk(0, rq, 0, 1);
    cpu_req = 0;
  endtask

  task automatic snoop_op(int cmd, logic [7:0] addr);
    int idx = int'(addr[2:0]);
    int tg = int'(addr[7:3]);
    bit hitl = m_st[idx] != 0 && m_tag[idx] == tg;
    bit ef = hitl && m_st[idx] == 2 && (cmd == 1 || cmd == 2);
    string rq = !hitl ? "R8" : (m_st[idx] == 2 ? (cmd == 1 ? "R5" : (cmd == 2 ? "R6" : "R8"))
                               : (cmd == 2 ? "R7" : "R8"));
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = addr;
    #1;
    chk(snp_flush == ef, rq, snp_flush, ef);
    if (ef) chk(snp_data == m_data[idx], rq, snp_data, m_data[idx]);
    chk(!bus_req && !cpu_ready, "R10", bus_req, 0);
    if (ef) mem[addr] = m_data[idx];
    if (hitl && cmd == 2) m_st[idx] = 0;
    else if (hitl && cmd == 1 && m_st[idx] == 2) m_st[idx] = 1;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned sd = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_ready && !bus_req && !snp_flush, "R1", bus_req, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = 8'(i + 8 * (i % 3)); #1;
      chk(bus_req && bus_cmd == 2'd1, "R1", {bus_req, bus_cmd}, 5);
    end
    @(negedge clk); cpu_req = 0;

    cpu_op(0, 8'h0A, 0);     // R2 miss
    cpu_op(0, 8'h0A, 0);     // R4 hit shared
    cpu_op(1, 8'h0A, 8'h5C); // R3 upgrade
    cpu_op(1, 8'h0A, 8'h6D); // R4 hit modified
    cpu_op(0, 8'h0A, 0);
    snoop_op(1, 8'h0A);      // R5
    cpu_op(0, 8'h0A, 0);
    cpu_op(1, 8'h0A, 8'h71); // expects exclusive fetch: line was Shared
    snoop_op(2, 8'h0A);      // R6
    cpu_op(0, 8'h0A, 0);
    snoop_op(1, 8'h0A);      // R8 shared, no action
    cpu_op(0, 8'h0A, 0);
    snoop_op(3, 8'h0A);      // R8 writeback ignored
    snoop_op(2, 8'h12);      // R8 tag miss
    cpu_op(0, 8'h0A, 0);
    snoop_op(2, 8'h0A);      // R7
    cpu_op(0, 8'h0A, 0);
    cpu_op(1, 8'h0B, 8'h3E);
    cpu_op(0, 8'h13, 0);     // R9 victim writeback then fetch

    // R11: pending writeback, victim snooped away
    cpu_op(1, 8'h0C, 8'h99);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h14; cpu_wdata = 8'h42; #1;
    chk(bus_req && bus_cmd == 2'd3 && bus_addr == 8'h0C, "R9", bus_addr, 8'h0C);
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h0C; #1;
    chk(!bus_req && !cpu_ready, "R10", bus_req, 0);
    chk(snp_flush && snp_data == 8'h99, "R6", snp_data, 8'h99);
    mem[8'h0C] = 8'h99; m_st[4] = 0;
    @(negedge clk);
    snp_valid = 0; #1;
    chk(bus_req && bus_cmd == 2'd2 && bus_addr == 8'h14, "R11",
        {bus_cmd, bus_addr}, 2 * 256 + 8'h14);
    @(negedge clk); cpu_req = 0;
    cpu_op(1, 8'h14, 8'h42);
    cpu_op(0, 8'h14, 0);

    for (int i = 0; i < 700; i++) begin
      int r = int'($urandom % 10);
      logic [7:0] a = 8'({$urandom % 3, 3'($urandom)});
      if (r < 4) cpu_op(0, a, 0);
      else if (r < 7) cpu_op(1, a, 8'($urandom));
      else snoop_op(int'($urandom % 3) + 1, a);
    end

    if (sd == 0) checks++;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule